// File: doc/BRIEF.md
# Dual-Field Radix-4 Montgomery Multiplier

This block forms the Montgomery product of two operands in one of two fields, chosen per operation. In prime mode it returns a value congruent to a·b·2^-(N+2) modulo an odd modulus p. In binary mode the same datapath treats a, b and p as polynomials over GF(2), with p an irreducible field polynomial, and returns a(x)·b(x)·x^-(N+2) mod p(x). Constants such as 2^(N+2) mod p and its square are produced elsewhere, and so are inversion and any curve-level sequencing.

The multiplier operand b is consumed two bits per cycle. A radix-4 quotient digit is chosen each cycle from the low bits of the running state. The state is kept as separate sum and carry vectors plus a one-bit carry-in. After (N+2)/2 digit cycles the same compressor tree is stepped with zero operands until the carry vector and carry-in are empty, which leaves the binary result in the sum vector. In binary mode every carry is gated off, so each compressor stage acts as a bank of XOR gates and the carry vector stays empty.

Top module: `dual_mont_mul`

## Requirements
- R1: While reset is asserted, and through the synchronized release of reset, `done` is 0 and `result` is 0. A reset in the middle of an operation abandons it with no `done` pulse.
- R2: With `bin_mode` = 0, odd `modulus` p and operands below 2p, `result` is congruent to a·b·2^-(N+2) mod p and is strictly below 2p.
- R3: With `bin_mode` = 1, bit i of an operand or of `modulus` is the coefficient of x^i. For operands of lower degree than p, `result` equals a(x)·b(x)·x^-(N+2) mod p(x) exactly, with degree below that of p.
- R4: `done` is high for exactly one cycle per operation. `result` changes only in the cycle `done` is high and holds its value until the next completion.
- R5: A `start` while an operation is in progress is ignored. Operand, modulus and mode inputs are sampled only on the accepted `start` edge.
- R6: In binary mode `done` rises exactly (N+2)/2+1 cycles after the accepted `start` edge. In prime mode it rises no earlier than that and no later than N+4 further cycles.
- R7: A `start` in the cycle that `done` is high is accepted and begins a new operation.
- R8: Operands at the boundary values 0 and 2p−1 give results that meet R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begins an operation when the block is idle |
| bin_mode | input | 1 | 1 selects GF(2) polynomial arithmetic, 0 selects prime-field arithmetic |
| op_a | input | N+1 | Multiplicand a |
| op_b | input | N+1 | Multiplier b, scanned two bits per cycle |
| modulus | input | N | Odd modulus p or field polynomial p(x) |
| done | output | 1 | One-cycle completion pulse |
| result | output | N+1 | Montgomery product, held between completions |

## Verification
A wrong quotient digit leaves nonzero bits below the shift point, so the carried-out residue breaks the congruence. That error becomes visible in `result` at the next `done` pulse, about (N+2)/2+1 cycles after start. A carry that leaks in binary mode shows up as a result of too high a degree, or as an extra conversion cycle, and so also shifts `done` in time. A stuck or miscounted digit counter shows at once as a `done` that comes early or late against the fixed binary-mode latency. An operand captured at the wrong time appears as a wrong product when a second `start` or changed inputs are applied during an operation.

// File: rtl/dmm_pkg.sv
package dmm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOP = 2'd1,
    ST_CONV = 2'd2
  } dmm_state_e;
endpackage

// File: rtl/dmm_csa.sv
// One carry-save compressor row; carries can be gated off for GF(2) mode.
module dmm_csa #(
  parameter int W = 12
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic         cin,
  input  logic         carry_en,
  output logic [W-1:0] sum,
  output logic [W-1:0] cy
);
  logic [W-2:0] maj;

  always_comb begin
    sum = x ^ y ^ z;
    maj = (x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]);
    cy  = carry_en ? {maj, cin} : '0;
  end
endmodule

// File: rtl/dmm_qsel.sv
// Radix-4 quotient digit selection for both fields.
module dmm_qsel (
  input  logic       bin_mode,
  input  logic [1:0] s_lo,
  input  logic [1:0] c_lo,
  input  logic       cin,
  input  logic [1:0] digit,
  input  logic [1:0] a_lo,
  input  logic [1:0] p_lo,
  output logic [1:0] q
);
  logic [1:0] da;
  logic [1:0] t_int;
  logic [1:0] tp;
  logic [1:0] t_bin;

  always_comb begin
    // integer view: low two bits of state plus digit*a
    da    = (digit[0] ? a_lo : 2'b00) + (digit[1] ? {a_lo[0], 1'b0} : 2'b00);
    t_int = s_lo + c_lo + {1'b0, cin} + da;
    // odd p is its own inverse mod 4, so q = -t*p mod 4
    tp    = t_int * p_lo;
    // polynomial view: carries absent, p0 = 1
    t_bin = s_lo ^ (digit[0] ? a_lo : 2'b00) ^ (digit[1] ? {a_lo[0], 1'b0} : 2'b00);
    if (bin_mode) q = {t_bin[1] ^ (t_bin[0] & p_lo[1]), t_bin[0]};
    else          q = 2'b00 - tp;
  end
endmodule

// File: rtl/dmm_tree.sv
// Four-row compressor: state (s, c, cin) plus two multiples of a and two of p.
module dmm_tree #(
  parameter int W = 12
) (
  input  logic         carry_en,
  input  logic [W-1:0] s_in,
  input  logic [W-1:0] c_in,
  input  logic         cin,
  input  logic [W-1:0] a1,
  input  logic [W-1:0] a2,
  input  logic [W-1:0] p1,
  input  logic [W-1:0] p2,
  output logic [W-1:0] s_out,
  output logic [W-1:0] c_out
);
  localparam int ROWS = 4;

  logic [W-1:0] rx [ROWS];
  logic [W-1:0] ry [ROWS];
  logic [W-1:0] rz [ROWS];
  logic [W-1:0] rs [ROWS];
  logic [W-1:0] rc [ROWS];

  always_comb begin
    rx[0] = s_in;  ry[0] = c_in;  rz[0] = a1;
    rx[1] = a2;    ry[1] = p1;    rz[1] = p2;
    rx[2] = rs[0]; ry[2] = rc[0]; rz[2] = rs[1];
    rx[3] = rs[2]; ry[3] = rc[2]; rz[3] = rc[1];
  end

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    dmm_csa #(.W(W)) u_csa (
      .x        (rx[g]),
      .y        (ry[g]),
      .z        (rz[g]),
      .cin      ((g == 0) ? cin : 1'b0),
      .carry_en (carry_en),
      .sum      (rs[g]),
      .cy       (rc[g])
    );
  end

  assign s_out = rs[ROWS-1];
  assign c_out = rc[ROWS-1];
endmodule

// File: rtl/dual_mont_mul.sv
module dual_mont_mul
  import dmm_pkg::*;
#(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         bin_mode,
  input  logic [N:0]   op_a,
  input  logic [N:0]   op_b,
  input  logic [N-1:0] modulus,
  output logic         done,
  output logic [N:0]   result
);
  localparam int AW = N + 1;
  localparam int W  = N + 4;
  localparam int K  = (N + 2) / 2;
  localparam int BW = 2 * K;
  localparam int CW = $clog2(K + 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  dmm_state_e     st_q, st_n;
  logic [W-1:0]   s_q, s_n, c_q, c_n;
  logic           cin_q, cin_n;
  logic [AW-1:0]  a_q;
  logic [N-1:0]   p_q;
  logic [BW-1:0]  b_q, b_n;
  logic [CW-1:0]  cnt_q, cnt_n;
  logic           bin_q;
  logic [AW-1:0]  res_q, res_n;
  logic           done_q, done_n;
  logic           op_ld, acc_en, res_en;

  logic [1:0]     q_dig;
  logic [W-1:0]   t_a1, t_a2, t_p1, t_p2, ts, tc;
  logic           in_loop;

  assign in_loop = (st_q == ST_LOOP);

  dmm_qsel u_qsel (
    .bin_mode (bin_q),
    .s_lo     (s_q[1:0]),
    .c_lo     (c_q[1:0]),
    .cin      (cin_q),
    .digit    (b_q[1:0]),
    .a_lo     (a_q[1:0]),
    .p_lo     (p_q[1:0]),
    .q        (q_dig)
  );

  always_comb begin
    t_a1 = (in_loop && b_q[0])  ? W'(a_q)         : '0;
    t_a2 = (in_loop && b_q[1])  ? (W'(a_q) << 1)  : '0;
    t_p1 = (in_loop && q_dig[0]) ? W'(p_q)        : '0;
    t_p2 = (in_loop && q_dig[1]) ? (W'(p_q) << 1) : '0;
  end

  dmm_tree #(.W(W)) u_tree (
    .carry_en (!bin_q),
    .s_in     (s_q),
    .c_in     (c_q),
    .cin      (cin_q),
    .a1       (t_a1),
    .a2       (t_a2),
    .p1       (t_p1),
    .p2       (t_p2),
    .s_out    (ts),
    .c_out    (tc)
  );

  // next-state logic
  always_comb begin
    st_n   = st_q;
    s_n    = s_q;
    c_n    = c_q;
    cin_n  = cin_q;
    b_n    = b_q;
    cnt_n  = cnt_q;
    res_n  = res_q;
    done_n = 1'b0;
    op_ld  = 1'b0;
    acc_en = 1'b0;
    res_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          op_ld  = 1'b1;
          acc_en = 1'b1;
          s_n    = '0;
          c_n    = '0;
          cin_n  = 1'b0;
          b_n    = BW'(op_b);
          cnt_n  = '0;
          st_n   = ST_LOOP;
        end
      end
      ST_LOOP: begin
        acc_en = 1'b1;
        s_n    = ts >> 2;
        c_n    = tc >> 2;
        cin_n  = ts[1] & tc[1];   // carry out of the two discarded bits
        b_n    = b_q >> 2;
        cnt_n  = cnt_q + 1'b1;
        if (cnt_q == CW'(K - 1)) st_n = ST_CONV;
      end
      ST_CONV: begin
        if (c_q == '0 && !cin_q) begin
          res_en = 1'b1;
          res_n  = s_q[AW-1:0];
          done_n = 1'b1;
          st_n   = ST_IDLE;
        end else begin
          acc_en = 1'b1;
          s_n    = ts;
          c_n    = tc;
          cin_n  = 1'b0;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      st_q   <= ST_IDLE;
      s_q    <= '0;
      c_q    <= '0;
      cin_q  <= 1'b0;
      a_q    <= '0;
      p_q    <= '0;
      b_q    <= '0;
      cnt_q  <= '0;
      bin_q  <= 1'b0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      done_q <= done_n;
      if (op_ld) begin
        a_q   <= op_a;
        p_q   <= modulus;
        bin_q <= bin_mode;
      end
      if (acc_en) begin
        s_q   <= s_n;
        c_q   <= c_n;
        cin_q <= cin_n;
        b_q   <= b_n;
        cnt_q <= cnt_n;
      end
      if (res_en) res_q <= res_n;
    end
  end

  assign done   = done_q;
  assign result = res_q;
endmodule

// File: rtl/dmm_checker.sv
module dmm_checker
  import dmm_pkg::*;
#(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_ni,
  input logic         done,
  input logic [N:0]   result,
  input dmm_state_e   st_q,
  input logic         bin_q,
  input logic [N+3:0] c_q,
  input logic         cin_q,
  input logic [N:0]   a_q,
  input logic [N-1:0] p_q
);
  int degp;
  always_comb begin
    degp = 0;
    for (int i = 0; i < N; i++) if (p_q[i]) degp = i;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    done |=> !done); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_ni)
    !done |-> $stable(result)); // R4
  AST_PRIME_BOUND: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && !bin_q) |-> (result < {p_q, 1'b0})); // R2
  AST_BIN_NO_CARRY: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q != ST_IDLE && bin_q) |-> (c_q == '0 && !cin_q)); // R3
  AST_BIN_DEGREE: assert property (@(posedge clk) disable iff (!rst_ni)
    (done && bin_q) |-> ((result >> degp) == '0)); // R3
  AST_OPERANDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_ni)
    (st_q == ST_LOOP) |=> ($stable(a_q) && $stable(p_q) && $stable(bin_q))); // R5
endmodule

bind dual_mont_mul dmm_checker #(.N(N)) u_dmm_chk (
  .clk    (clk),
  .rst_ni (rst_sync_q),
  .done   (done),
  .result (result),
  .st_q   (st_q),
  .bin_q  (bin_q),
  .c_q    (c_q),
  .cin_q  (cin_q),
  .a_q    (a_q),
  .p_q    (p_q)
);

// File: tb/dual_mont_mul_bench.sv
module dual_mont_mul_bench;
  localparam int N  = 8;
  localparam int K  = (N + 2) / 2;
  localparam int NV = 12;

  // {bin_mode, a[8:0], b[8:0], p[7:0]}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0, 9'd100, 9'd200, 8'd251},
    {1'b0, 9'd500, 9'd501, 8'd251},
    {1'b0, 9'd25,  9'd25,  8'd13},
    {1'b0, 9'd5,   9'd4,   8'd3},
    {1'b0, 9'd509, 9'd509, 8'd255},
    {1'b0, 9'd1,   9'd1,   8'd191},
    {1'b0, 9'd377, 9'd123, 8'd199},
    {1'b1, 9'h05A, 9'h071, 8'h83},
    {1'b1, 9'h07F, 9'h07F, 8'h83},
    {1'b1, 9'h00F, 9'h009, 8'h13},
    {1'b1, 9'h01C, 9'h013, 8'h25},
    {1'b1, 9'h006, 9'h005, 8'h0B}
  };

  logic         clk;
  logic         rst_n;
  logic         start;
  logic         bin_mode;
  logic [N:0]   op_a;
  logic [N:0]   op_b;
  logic [N-1:0] modulus;
  logic         done;
  logic [N:0]   result;

  int checks;
  int errors;
  bit finished;

  dual_mont_mul #(.N(N)) u_dual_mont_mul (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .bin_mode (bin_mode),
    .op_a     (op_a),
    .op_b     (op_b),
    .modulus  (modulus),
    .done     (done),
    .result   (result)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic longint ref_prime(longint a, longint b, longint p);
    longint r;
    r = (a * b) % p;
    for (int i = 0; i < N + 2; i++) begin
      if (r[0]) r = r + p;
      r = r >> 1;
    end
    return r % p;
  endfunction

  function automatic longint ref_bin(longint a, longint b, longint p);
    longint prod, r;
    int deg;
    prod = 0;
    for (int i = 0; i < 2 * N; i++) if (b[i]) prod = prod ^ (a << i);
    deg = 0;
    for (int i = 0; i < N; i++) if (p[i]) deg = i;
    r = prod;
    for (int i = 2 * N + 1; i >= deg; i--) if (r[i]) r = r ^ (p << (i - deg));
    for (int i = 0; i < N + 2; i++) begin
      if (r[0]) r = r ^ p;
      r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input bit m, input logic [N:0] a, input logic [N:0] b, input logic [N-1:0] p);
    bin_mode = m;
    op_a     = a;
    op_b     = b;
    modulus  = p;
  endtask

  // start at a negedge, then count edges until done is seen
  task automatic run_op(input bit m, input logic [N:0] a, input logic [N:0] b,
                        input logic [N-1:0] p, output logic [N:0] res, output int lat);
    @(negedge clk);
    drive(m, a, b, p);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      #1 lat++;
    end while (!done && lat < 100);
    res = result;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N:0] res, res2;
    int lat;
    longint exp;
    checks = 0;
    errors = 0;
    finished = 0;
    start = 1'b0;
    drive(1'b0, '0, '0, 8'd1);
    rst_n = 1'b0;
    #23;
    check(done == 1'b0 && result == '0, "R1 during reset", result, 0);
    do_reset();
    check(done == 1'b0 && result == '0, "R1 after release", result, 0);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic m;
      logic [N:0] va, vb;
      logic [N-1:0] vp;
      {m, va, vb, vp} = VEC[v];
      run_op(m, va, vb, vp, res, lat);
      if (m) begin
        exp = ref_bin(va, vb, vp);
        check(res == exp, "R3 binary product", res, exp);
        check(lat == K + 1, "R6 binary latency", lat, K + 1);
      end else begin
        exp = ref_prime(va, vb, vp);
        check((res % vp) == exp && res < 2 * vp, "R2 prime product", res, exp);
        check(lat >= K + 1 && lat <= K + 1 + N + 4, "R6 prime latency", lat, K + 1);
      end
      // R4: pulse drops next cycle, result held
      res2 = result;
      @(posedge clk);
      #1 check(done == 1'b0, "R4 done one cycle", done, 0);
      repeat (3) @(posedge clk);
      #1 check(result == res2, "R4 result held", result, res2);
    end

    // R8 boundary operands
    run_op(1'b0, 9'd0, 9'd300, 8'd251, res, lat);
    check((res % 251) == 0 && res < 502, "R8 zero operand", res, 0);
    run_op(1'b0, 9'd501, 9'd501, 8'd251, res, lat);
    exp = ref_prime(501, 501, 251);
    check((res % 251) == exp && res < 502, "R8 max operands", res, exp);
    run_op(1'b0, 9'd253, 9'd1, 8'd127, res, lat);
    exp = ref_prime(253, 1, 127);
    check((res % 127) == exp && res < 254, "R8 max operand small p", res, exp);

    // R5: start and new inputs during an operation are ignored
    @(negedge clk);
    drive(1'b0, 9'd200, 9'd150, 8'd211);
    start = 1'b1;
    @(negedge clk);
    drive(1'b1, 9'h1FF, 9'h1FF, 8'h83);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 100) begin
      @(posedge clk);
      #1 lat++;
    end
    exp = ref_prime(200, 150, 211);
    check((result % 211) == exp && result < 422, "R5 busy start ignored", result, exp);
    @(posedge clk);
    #1 check(done == 1'b0, "R5 no second completion", done, 0);

    // R7: start in the done cycle
    run_op(1'b1, 9'h03C, 9'h02B, 8'h83, res, lat);
    drive(1'b1, 9'h011, 9'h066, 8'h83);
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      #1 lat++;
    end while (!done && lat < 100);
    exp = ref_bin(9'h011, 9'h066, 8'h83);
    check(result == exp, "R7 back-to-back product", result, exp);
    check(lat == K + 1, "R7 back-to-back latency", lat, K + 1);

    // R1: reset mid-operation
    @(negedge clk);
    drive(1'b0, 9'd77, 9'd88, 8'd101);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1 check(done == 1'b0 && result == '0, "R1 reset mid-op", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      #1 if (done) lat++;
    end
    check(lat == 0 && result == '0, "R1 abandoned op", lat, 0);
    run_op(1'b0, 9'd77, 9'd88, 8'd101, res, lat);
    exp = ref_prime(77, 88, 101);
    check((res % 101) == exp && res < 202, "R2 after reset", res, exp);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule